// File: doc/BRIEF.md
# Burst-of-Four Double-Rate Read Pipeline

This block is the read side of a synchronous SRAM that has separate input and output ports. Each read command carries a word index. The block fetches one internal word that is four bus beats wide and streams it out as four beats on consecutive half-periods of the bus clock. A data-valid strobe runs alongside the beats. The first beat appears two and a half bus cycles after the command is sampled.

Timing is modelled with one fast clock at twice the bus rate, so one fast cycle is one beat slot. The block derives the bus phase itself and publishes it on `k_slot`. Commands are sampled only on fast-clock edges that stand for a rising bus-clock edge. A write port fills the internal register array. Writes pass through a short pipeline before they land in the array, and reads forward data from that pipeline so they see every write sampled no later than themselves.

Top module: `quad_beat_sram_rd`

## Requirements
- R1: While reset is held and in the cycle after it, `q_out` is 0, `q_vld` is 0, `rd_err` is 0 and `k_slot` is 1.
- R2: Beat k of a burst (k = 0..3) is bits [k*BEAT_W +: BEAT_W] of the stored word. Beat 0, the least significant quarter, comes first.
- R3: `k_slot` toggles every fast cycle. A read accepted at the edge ending a cycle with `k_slot` = 1 puts beat 0 on `q_out` after the 5th following edge, which is 2.5 bus cycles. Beats 1..3 follow on the next three fast cycles.
- R4: `q_vld` is 1 exactly in the fast cycles that carry a beat of an accepted read, four per read, and 0 otherwise.
- R5: Reads accepted four fast cycles apart (every bus cycle pair) give a gapless stream: `q_vld` stays 1 across the bursts and the data continues in order.
- R6: A read sampled two fast cycles after an accepted read is ignored and produces no beats. `rd_err` is 1 for the one fast cycle after that edge. A read two fast cycles later still is accepted.
- R7: `rd_n` and `wr_n` are active low and are only sampled on edges ending a `k_slot` = 1 cycle. A low level in a `k_slot` = 0 cycle has no effect.
- R8: A read returns data from writes sampled in the same slot or earlier, even while those writes are still in the write pipeline. A write sampled in a later slot does not affect a read already accepted.
- R9: A write (`wr_n` = 0) stores the full word `wr_word` at `wr_addr`, and later reads return it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, one cycle per beat slot |
| rst | input | 1 | Synchronous active-high reset |
| k_slot | output | 1 | 1 in cycles whose ending edge stands for a rising bus-clock edge |
| rd_n | input | 1 | Read command, active low |
| rd_addr | input | ADDR_W | Word index of the read |
| wr_n | input | 1 | Write command, active low |
| wr_addr | input | ADDR_W | Word index of the write |
| wr_word | input | 4*BEAT_W | Full word to store |
| q_out | output | BEAT_W | Read data beat |
| q_vld | output | 1 | High while `q_out` carries a beat |
| rd_err | output | 1 | One-cycle pulse when a read is ignored for spacing |

## Verification
A write and a read can be sampled on the same slot edge, which is also the edge at which an earlier write is committing to the array. The bench provokes this by issuing both commands to the same index in one slot. It also places a write one slot before a read, and a write one slot after a read. Its memory model applies same-slot writes before it computes the read's expected beats, so new data is expected in the first two cases and old data in the third. Every fast cycle is then compared beat by beat.

// File: rtl/qb_pkg.sv
package qb_pkg;
  localparam int unsigned BEATS      = 4;  // beats per internal word
  localparam int unsigned READ_SLOTS = 5;  // 2.5 bus cycles in fast slots
  localparam int unsigned MIN_GAP    = 4;  // fast cycles between accepted reads
  localparam int unsigned WR_STAGES  = 2;  // write pipeline depth before commit
endpackage

// File: rtl/qb_array.sv
module qb_array #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/qb_wr_stage.sv
module qb_wr_stage #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_v,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [WORD_W-1:0] in_data,
  output logic              commit_v,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [WORD_W-1:0] commit_data,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              look_hit,
  output logic [WORD_W-1:0] look_data
);
  logic              st_v [STAGES];
  logic [ADDR_W-1:0] st_a [STAGES];
  logic [WORD_W-1:0] st_d [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st_v[0] <= 1'b0;
    else     st_v[0] <= in_v;
    st_a[0] <= in_addr;
    st_d[0] <= in_data;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st_v[i] <= 1'b0;
      else     st_v[i] <= st_v[i-1];
      st_a[i] <= st_a[i-1];
      st_d[i] <= st_d[i-1];
    end
  end

  assign commit_v    = st_v[STAGES-1];
  assign commit_addr = st_a[STAGES-1];
  assign commit_data = st_d[STAGES-1];

  // youngest stage is scanned last so it wins
  always_comb begin
    look_hit  = 1'b0;
    look_data = '0;
    for (int i = STAGES - 1; i >= 0; i--) begin
      if (st_v[i] && st_a[i] == look_addr) begin
        look_hit  = 1'b1;
        look_data = st_d[i];
      end
    end
  end

  // R8: a write pulse on the input always reaches the commit stage
  a_r8_reaches_commit: assert property (@(posedge clk) disable iff (rst)
    $rose(st_v[0]) |-> ##(STAGES-1) commit_v);
endmodule

// File: rtl/qb_serializer.sv
module qb_serializer #(
  parameter int unsigned BEAT_W = 8,
  parameter int unsigned BEATS  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [BEATS*BEAT_W-1:0] word,
  output logic [BEAT_W-1:0]       q,
  output logic                    qvld
);
  localparam int unsigned IDX_W = $clog2(BEATS);

  logic [BEATS-1:0][BEAT_W-1:0] hold;
  logic [IDX_W-1:0]             bidx;
  logic                         busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      qvld <= 1'b0;
      bidx <= '0;
      busy <= 1'b0;
    end else if (load) begin
      hold <= word;
      q    <= word[BEAT_W-1:0];
      qvld <= 1'b1;
      bidx <= IDX_W'(1);
      busy <= 1'b1;
    end else if (busy) begin
      q    <= hold[bidx];
      qvld <= 1'b1;
      bidx <= bidx + IDX_W'(1);
      busy <= (bidx != IDX_W'(BEATS - 1));
    end else begin
      q    <= '0;
      qvld <= 1'b0;
    end
  end

  // R4: every run of valid ends after four beats (or a multiple)
  a_r4_four_beats: assert property (@(posedge clk) disable iff (rst)
    $fell(qvld) |-> $past(qvld, 4));

  // R2: the first beat is the low quarter of the loaded word
  a_r2_low_first: assert property (@(posedge clk) disable iff (rst)
    load |=> (qvld && q == $past(word[BEAT_W-1:0])));
endmodule

// File: rtl/quad_beat_sram_rd.sv
module quad_beat_sram_rd #(
  parameter int unsigned BEAT_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  output logic                                k_slot,
  input  logic                                rd_n,
  input  logic [ADDR_W-1:0]                   rd_addr,
  input  logic                                wr_n,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [qb_pkg::BEATS*BEAT_W-1:0]     wr_word,
  output logic [BEAT_W-1:0]                   q_out,
  output logic                                q_vld,
  output logic                                rd_err
);
  import qb_pkg::*;

  localparam int unsigned WORD_W = BEATS * BEAT_W;
  localparam int unsigned GAP_W  = $clog2(MIN_GAP);
  localparam int unsigned TOK_N  = READ_SLOTS;

  logic              kslot_r;
  logic [GAP_W-1:0]  gap;
  logic              rd_take, rd_drop, wr_take;
  logic [TOK_N-1:0]  tok;
  logic [ADDR_W-1:0] req_addr;

  logic              cm_v;
  logic [ADDR_W-1:0] cm_a;
  logic [WORD_W-1:0] cm_d;
  logic              fw_hit, fw_hit_r;
  logic [WORD_W-1:0] fw_data, fw_data_r;
  logic [WORD_W-1:0] arr_q, fetched;

  assign k_slot  = kslot_r;
  assign rd_take = kslot_r && !rd_n && (gap == '0);
  assign rd_drop = kslot_r && !rd_n && (gap != '0);
  assign wr_take = kslot_r && !wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      kslot_r <= 1'b1;
      gap     <= '0;
      tok     <= '0;
      rd_err  <= 1'b0;
    end else begin
      kslot_r <= !kslot_r;
      if (rd_take)        gap <= GAP_W'(MIN_GAP - 1);
      else if (gap != '0) gap <= gap - GAP_W'(1);
      tok    <= {tok[TOK_N-2:0], rd_take};
      rd_err <= rd_drop;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_take) req_addr <= rd_addr;
  end

  qb_wr_stage #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .STAGES (WR_STAGES)
  ) u_wr (
    .clk         (clk),
    .rst         (rst),
    .in_v        (wr_take),
    .in_addr     (wr_addr),
    .in_data     (wr_word),
    .commit_v    (cm_v),
    .commit_addr (cm_a),
    .commit_data (cm_d),
    .look_addr   (req_addr),
    .look_hit    (fw_hit),
    .look_data   (fw_data)
  );

  qb_array #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
  ) u_arr (
    .clk   (clk),
    .we    (cm_v),
    .waddr (cm_a),
    .wdata (cm_d),
    .re    (tok[0]),
    .raddr (req_addr),
    .rdata (arr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fw_hit_r <= 1'b0;
    end else if (tok[0]) begin
      fw_hit_r <= fw_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (tok[0]) fw_data_r <= fw_data;
  end

  assign fetched = fw_hit_r ? fw_data_r : arr_q;

  qb_serializer #(
    .BEAT_W (BEAT_W),
    .BEATS  (BEATS)
  ) u_ser (
    .clk  (clk),
    .rst  (rst),
    .load (tok[TOK_N-1]),
    .word (fetched),
    .q    (q_out),
    .qvld (q_vld)
  );

  // R3: a token leaving the delay line puts a beat on the bus next cycle
  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    tok[TOK_N-1] |=> q_vld);

  // R5: accepted reads in flight are spaced by at least the minimum gap
  a_r5_spacing: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tok[TOK_N-2:0]));

  // R6: an ignored read never starts a fetch
  a_r6_no_issue: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> !tok[0]);

  // R7: reads are only accepted on the rising-bus-edge slot
  a_r7_slot_only: assert property (@(posedge clk) disable iff (rst)
    tok[0] |-> !kslot_r);
endmodule

// File: tb/quad_beat_sram_rd_bench.sv
module quad_beat_sram_rd_bench;
  localparam int BW   = 8;
  localparam int AW   = 4;
  localparam int WW   = 4 * BW;
  localparam int NW   = 1 << AW;
  localparam int MAXC = 8192;

  logic          clk = 1'b0;
  logic          rst;
  logic          k_slot;
  logic          rd_n;
  logic [AW-1:0] rd_addr;
  logic          wr_n;
  logic [AW-1:0] wr_addr;
  logic [WW-1:0] wr_word;
  logic [BW-1:0] q_out;
  logic          q_vld;
  logic          rd_err;

  always #2 clk = ~clk;

  quad_beat_sram_rd #(.BEAT_W(BW), .ADDR_W(AW)) u_quad_beat_sram_rd (
    .clk(clk), .rst(rst), .k_slot(k_slot),
    .rd_n(rd_n), .rd_addr(rd_addr),
    .wr_n(wr_n), .wr_addr(wr_addr), .wr_word(wr_word),
    .q_out(q_out), .q_vld(q_vld), .rd_err(rd_err)
  );

  int            cyc = 0;
  int            checks = 0;
  int            fails = 0;
  bit            chk_on = 1'b0;
  bit            done = 1'b0;
  int            last_acc = -100;
  bit            exp_v [MAXC];
  logic [BW-1:0] exp_d [MAXC];
  bit            exp_e [MAXC];
  string         exp_t [MAXC];
  logic [WW-1:0] model [NW];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [WW-1:0] pat(int a, int p);
    return {8'(a * 17 + p * 5), 8'(p * 29 + 3), 8'(a ^ 8'hA5), 8'(a + p * 7 + 1)};
  endfunction

  // per-cycle comparison of beats, valid and the error pulse
  always @(negedge clk) begin
    if (chk_on && !done && cyc < MAXC) begin
      checks++;
      if (q_vld !== exp_v[cyc] || (exp_v[cyc] && q_out !== exp_d[cyc])) begin
        fails++;
        $display("FAIL %s cycle %0d: vld=%0b data=%h expected vld=%0b data=%h",
                 exp_t[cyc], cyc, q_vld, q_out, exp_v[cyc], exp_d[cyc]);
      end
      checks++;
      if (rd_err !== exp_e[cyc]) begin
        fails++;
        $display("FAIL R6 cycle %0d: rd_err=%0b expected %0b", cyc, rd_err, exp_e[cyc]);
      end
    end
  end

  task automatic slot(bit r, int ra, bit w, int wa, logic [WW-1:0] wd, string tag);
    int e0;
    @(negedge clk);
    while (!k_slot) @(negedge clk);
    e0 = cyc + 1;
    if (w) begin
      wr_n = 1'b0; wr_addr = AW'(wa); wr_word = wd;
      model[wa] = wd;
    end
    if (r) begin
      rd_n = 1'b0; rd_addr = AW'(ra);
      if (e0 - last_acc < 4) begin
        exp_e[e0] = 1'b1;
      end else begin
        last_acc = e0;
        for (int k = 0; k < 4; k++) begin
          exp_v[e0 + 5 + k] = 1'b1;
          exp_d[e0 + 5 + k] = model[ra][k*BW +: BW];
          exp_t[e0 + 5 + k] = tag;
        end
      end
    end
    @(posedge clk);
    #1 rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic offslot(int a, logic [WW-1:0] wd);
    @(negedge clk);
    while (k_slot) @(negedge clk);
    for (int k = 0; k < 12; k++) exp_t[cyc + 1 + k] = "R7";
    rd_n = 1'b0; rd_addr = AW'(a);
    wr_n = 1'b0; wr_addr = AW'(a); wr_word = wd;
    @(posedge clk);
    #1 rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (MAXC - 200) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, cycle=%0d expected below %0d", cyc, MAXC - 200);
    finish_run();
  end

  initial begin
    for (int i = 0; i < MAXC; i++) begin
      exp_v[i] = 1'b0; exp_d[i] = '0; exp_e[i] = 1'b0; exp_t[i] = "R4";
    end
    for (int i = 0; i < NW; i++) model[i] = '0;
    rst = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    rd_addr = '0; wr_addr = '0; wr_word = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (q_out !== '0 || q_vld !== 1'b0 || rd_err !== 1'b0 || k_slot !== 1'b1) begin
      fails++;
      $display("FAIL R1: q=%h vld=%0b err=%0b slot=%0b expected q=00 vld=0 err=0 slot=1",
               q_out, q_vld, rd_err, k_slot);
    end
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checks++;
    if (q_out !== '0 || q_vld !== 1'b0 || rd_err !== 1'b0 || k_slot !== 1'b1) begin
      fails++;
      $display("FAIL R1: after release q=%h vld=%0b err=%0b slot=%0b expected 00 0 0 1",
               q_out, q_vld, rd_err, k_slot);
    end
    chk_on = 1'b1;

    // R9 fill, then R5 back-to-back sweep of every index (R2 beat order)
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < NW; a++) slot(1'b0, 0, 1'b1, a, pat(a, p), "R9");
      for (int a = 0; a < NW; a++) begin
        slot(1'b1, a, 1'b0, 0, '0, "R5");
        slot(1'b0, 0, 1'b0, 0, '0, "R5");
      end
      idle(12);
    end

    // R3 isolated reads with gaps, R2 order checked on each beat
    for (int a = 0; a < NW; a += 5) begin
      slot(1'b1, a, 1'b0, 0, '0, "R3");
      idle(9 + a);
    end
    slot(1'b1, NW - 1, 1'b0, 0, '0, "R2");
    idle(12);

    // R6 read one bus cycle after an accepted read is dropped
    slot(1'b1, 3, 1'b0, 0, '0, "R6");
    slot(1'b1, 5, 1'b0, 0, '0, "R6");
    slot(1'b1, 7, 1'b0, 0, '0, "R6");
    idle(12);

    // R7 commands outside the sampling slot do nothing
    offslot(2, 32'hDEADBEEF);
    idle(3);
    slot(1'b1, 2, 1'b0, 0, '0, "R7");
    idle(12);

    // R8 coherence: same-slot write, earlier write, later write
    slot(1'b1, 4, 1'b1, 4, 32'h11223344, "R8");
    idle(12);
    slot(1'b0, 0, 1'b1, 6, 32'hA0B0C0D0, "R8");
    slot(1'b1, 6, 1'b0, 0, '0, "R8");
    idle(12);
    slot(1'b1, 8, 1'b0, 0, '0, "R8");
    slot(1'b0, 0, 1'b1, 8, 32'h5A5A0F0F, "R8");
    idle(12);
    slot(1'b1, 8, 1'b1, 9, 32'h01020304, "R8");
    slot(1'b0, 0, 1'b0, 0, '0, "R8");
    slot(1'b1, 9, 1'b0, 0, '0, "R8");
    idle(16);

    finish_run();
  end
endmodule